// File: doc/BRIEF.md
# Timer interrupt flag unit

This block keeps the two status flags of an 8-bit timer/counter: one for a compare match and one for an overflow. It turns each flag into an interrupt request. The counter feeds it single-cycle event strobes. It also supplies a mode bit that says up/down (PWM) counting is active, plus the current count direction.

In normal counting, the overflow flag follows the wrap strobe. In up/down counting, the wrap strobe is ignored. Instead, the overflow flag is raised when the counter turns from counting down to counting up at the bottom of its range.

Software reads the flags through an 8-bit status word. It clears a flag by writing a one into that flag's position. The interrupt controller can also clear a flag by pulsing that flag's acknowledge line when the vector is taken. A request line is high only while the global enable, the per-flag enable and the flag are all set.

Top module: `tmr_irq_flags`

## Requirements
- R1: While `rst` is high at a clock edge, both flags clear; after reset, `flags_o` reads 0x00 and `irq_o` reads 0.
- R2: A `cmp_evt_i` pulse sets `flags_o[1]` (the compare flag) at the next clock edge.
- R3: With `pwm_mode_i` low, an `ovf_evt_i` pulse sets `flags_o[0]` (the overflow flag) at the next clock edge.
- R4: With `pwm_mode_i` high, `ovf_evt_i` has no effect. Instead, `flags_o[0]` sets at the edge where `dir_down_i` is sampled 0 after having been sampled 1 at the previous edge. A change from up (0) to down (1) sets nothing.
- R5: With `wr_en_i` high, each flag whose bit in `wr_data_i` is 1 clears at the clock edge. A 0 bit leaves its flag unchanged.
- R6: A pulse on `ack_i[0]` clears the overflow flag, and a pulse on `ack_i[1]` clears the compare flag, at the clock edge.
- R7: When a set event and a clear (by write or acknowledge) reach the same flag in the same cycle, the flag ends up set.
- R8: `irq_o[k]` is high exactly while `gie_i`, `ien_i[k]` and `flags_o[k]` are all high. Bit 0 is overflow and bit 1 is compare. The output is combinational, with no added cycle.
- R9: `flags_o[7:2]` always read zero, and writes to those bit positions have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ovf_evt_i | input | 1 | Counter wrap strobe (used in normal mode) |
| cmp_evt_i | input | 1 | Compare-match strobe |
| pwm_mode_i | input | 1 | Up/down (PWM) counting active |
| dir_down_i | input | 1 | Current count direction, 1 = down |
| wr_en_i | input | 1 | Status word write strobe |
| wr_data_i | input | 8 | Status word write data (1 = clear that flag) |
| gie_i | input | 1 | Global interrupt enable |
| ien_i | input | 2 | Per-flag enables: bit 0 overflow, bit 1 compare |
| ack_i | input | 2 | Per-flag vector acknowledge strobes |
| flags_o | output | 8 | Status word: bit 0 overflow, bit 1 compare, others zero |
| irq_o | output | 2 | Interrupt requests: bit 0 overflow, bit 1 compare |

## Verification
On every cycle, the assertions check the following properties:
- every compare or normal-mode wrap strobe leaves its flag set one edge later;
- a turn from down to up in PWM mode sets the overflow flag;
- an uncontested write-one or acknowledge clears its flag;
- a flag holds when nothing clears it;
- no request is raised while the global enable is low.

Some behaviours only the bench scenarios can show:
- that a wrap strobe is really ignored in PWM mode;
- that set beats clear in the same cycle;
- that upper status bits stay zero after writes of ones.

The bench also runs a long randomly mixed stream of strobes, writes and acknowledges against its model.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;

    localparam int STAT_W  = 8;
    localparam int NFLAG   = 2;
    localparam int OVF_POS = 0;
    localparam int CMP_POS = 1;

    typedef logic [NFLAG-1:0] flag_vec_t;

    typedef struct packed {
        flag_vec_t set;
        flag_vec_t clr;
    } flag_ctl_t;

    function automatic flag_vec_t wr_clear_mask(input logic wr_en,
                                                input logic [STAT_W-1:0] wdata);
        flag_vec_t m;
        m = '0;
        if (wr_en) begin
            m = wdata[NFLAG-1:0];
        end
        return m;
    endfunction

    function automatic logic [STAT_W-1:0] to_status(input flag_vec_t f);
        logic [STAT_W-1:0] s;
        s = '0;
        s[NFLAG-1:0] = f;
        return s;
    endfunction

endpackage

// File: rtl/tmr_evt_decode.sv
module tmr_evt_decode
    import tmr_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ovf_evt,
    input  logic      cmp_evt,
    input  logic      pwm_mode,
    input  logic      dir_down,
    output flag_vec_t set_vec
);

    logic dir_down_q;
    logic turn_up;

    // direction history: loaded with the live direction during reset so the
    // first post-reset comparison is against a real sample
    always_ff @(posedge clk) begin
        dir_down_q <= dir_down;
    end

    assign turn_up = dir_down_q & ~dir_down;

    always_comb begin
        set_vec          = '0;
        set_vec[CMP_POS] = cmp_evt;
        set_vec[OVF_POS] = pwm_mode ? turn_up : ovf_evt;
    end

endmodule

// File: rtl/tmr_flag_bit.sv
module tmr_flag_bit (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end

endmodule

// File: rtl/tmr_irq_gate.sv
module tmr_irq_gate
    import tmr_irq_pkg::*;
(
    input  logic      gie,
    input  flag_vec_t en,
    input  flag_vec_t flags,
    output flag_vec_t req
);

    assign req = gie ? (en & flags) : '0;

endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
    import tmr_irq_pkg::*;
#(
    parameter int REG_W = STAT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ovf_evt_i,
    input  logic             cmp_evt_i,
    input  logic             pwm_mode_i,
    input  logic             dir_down_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             gie_i,
    input  logic [1:0]       ien_i,
    input  logic [1:0]       ack_i,
    output logic [REG_W-1:0] flags_o,
    output logic [1:0]       irq_o
);

    flag_ctl_t ctl;
    flag_vec_t flag_q;

    tmr_evt_decode u_dec (
        .clk      (clk),
        .rst      (rst),
        .ovf_evt  (ovf_evt_i),
        .cmp_evt  (cmp_evt_i),
        .pwm_mode (pwm_mode_i),
        .dir_down (dir_down_i),
        .set_vec  (ctl.set)
    );

    assign ctl.clr = wr_clear_mask(wr_en_i, wr_data_i[STAT_W-1:0]) | ack_i;

    for (genvar k = 0; k < NFLAG; k++) begin : g_flag
        tmr_flag_bit u_bit (
            .clk    (clk),
            .rst    (rst),
            .set_i  (ctl.set[k]),
            .clr_i  (ctl.clr[k]),
            .flag_o (flag_q[k])
        );
    end

    tmr_irq_gate u_gate (
        .gie   (gie_i),
        .en    (ien_i),
        .flags (flag_q),
        .req   (irq_o)
    );

    assign flags_o = REG_W'(to_status(flag_q));

endmodule

// File: rtl/tmr_irq_flags_chk.sv
module tmr_irq_flags_chk (
    input logic       clk,
    input logic       rst,
    input logic       ovf_evt_i,
    input logic       cmp_evt_i,
    input logic       pwm_mode_i,
    input logic       dir_down_i,
    input logic       wr_en_i,
    input logic [7:0] wr_data_i,
    input logic       gie_i,
    input logic [1:0] ack_i,
    input logic [7:0] flags_o,
    input logic [1:0] irq_o
);

    p_cmp_set_r2: assert property (@(posedge clk) disable iff (rst)
        cmp_evt_i |=> flags_o[1]);

    p_ovf_set_r3: assert property (@(posedge clk) disable iff (rst)
        (ovf_evt_i && !pwm_mode_i) |=> flags_o[0]);

    p_turn_up_r4: assert property (@(posedge clk) disable iff (rst)
        (pwm_mode_i && $past(dir_down_i) && !dir_down_i) |=> flags_o[0]);

    p_wr_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_data_i[1] && !cmp_evt_i) |=> !flags_o[1]);

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (flags_o[1] && !(wr_en_i && wr_data_i[1]) && !ack_i[1]) |=> flags_o[1]);

    p_ack_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (ack_i[1] && !cmp_evt_i) |=> !flags_o[1]);

    p_gie_gate_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_o != 2'b00) |-> gie_i);

endmodule

bind tmr_irq_flags tmr_irq_flags_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ovf_evt_i  (ovf_evt_i),
    .cmp_evt_i  (cmp_evt_i),
    .pwm_mode_i (pwm_mode_i),
    .dir_down_i (dir_down_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .gie_i      (gie_i),
    .ack_i      (ack_i),
    .flags_o    (flags_o),
    .irq_o      (irq_o)
);

// File: tb/tmr_irq_flags_test.sv
module tmr_irq_flags_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       ovf_evt_i, cmp_evt_i, pwm_mode_i, dir_down_i;
    logic       wr_en_i, gie_i;
    logic [7:0] wr_data_i;
    logic [1:0] ien_i, ack_i;
    logic [7:0] flags_o;
    logic [1:0] irq_o;

    int checks = 0;
    int errors = 0;
    logic [1:0] m_flags;
    logic       m_prev;

    always #10 clk = ~clk;

    tmr_irq_flags uut (
        .clk(clk), .rst(rst), .ovf_evt_i(ovf_evt_i), .cmp_evt_i(cmp_evt_i),
        .pwm_mode_i(pwm_mode_i), .dir_down_i(dir_down_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .gie_i(gie_i), .ien_i(ien_i), .ack_i(ack_i),
        .flags_o(flags_o), .irq_o(irq_o)
    );

    function automatic logic [1:0] exp_irq(logic [1:0] f, logic g, logic [1:0] e);
        return g ? (f & e) : 2'b00;
    endfunction

    function automatic logic [1:0] next_flags(logic [1:0] f, logic prev);
        logic [1:0] s, c;
        s[1] = cmp_evt_i;
        s[0] = pwm_mode_i ? (prev & ~dir_down_i) : ovf_evt_i;
        c = (wr_en_i ? wr_data_i[1:0] : 2'b00) | ack_i;
        return (f & ~c) | s;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic quiet();
        ovf_evt_i = 0; cmp_evt_i = 0; wr_en_i = 0; wr_data_i = 8'h00; ack_i = 2'b00;
    endtask

    // inputs are set at a falling edge; check the request now, advance one edge, check flags
    task automatic step(input string req);
        #1;
        chk({req, " irq (R8)"}, {30'b0, irq_o}, {30'b0, exp_irq(m_flags, gie_i, ien_i)});
        m_flags = next_flags(m_flags, m_prev);
        m_prev  = dir_down_i;
        @(negedge clk);
        chk({req, " flags"}, {24'b0, flags_o}, {30'b0, m_flags});
    endtask

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] seed_dummy;
        rst = 1; quiet(); pwm_mode_i = 0; dir_down_i = 0; gie_i = 0; ien_i = 2'b00;
        m_flags = 2'b00; m_prev = 1'b0;
        repeat (2) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 flags", {24'b0, flags_o}, 32'h0);
        chk("R1 irq", {30'b0, irq_o}, 32'h0);

        // R2 compare sets bit 1
        cmp_evt_i = 1; step("R2 compare set"); quiet();
        // R5 writing zero keeps, writing one clears
        wr_en_i = 1; wr_data_i = 8'h00; step("R5 zero write"); quiet();
        wr_en_i = 1; wr_data_i = 8'h02; step("R5 one clear"); quiet();
        // R3 normal-mode wrap
        ovf_evt_i = 1; step("R3 wrap set"); quiet();
        // R6 acknowledge clears overflow
        ack_i = 2'b01; step("R6 ack clear"); quiet();
        // R7 set beats write-one and acknowledge
        cmp_evt_i = 1; wr_en_i = 1; wr_data_i = 8'h02; step("R7 set vs write"); quiet();
        cmp_evt_i = 1; ack_i = 2'b10; step("R7 set vs ack"); quiet();
        chk("R7 flag kept", {24'b0, flags_o}, 32'h02);
        // R8 enable gating
        gie_i = 0; ien_i = 2'b11; step("R8 gie off");
        gie_i = 1; ien_i = 2'b01; step("R8 ien mismatch");
        ien_i = 2'b10; step("R8 both on");
        chk("R8 irq high", {30'b0, irq_o}, 32'h2);
        wr_en_i = 1; wr_data_i = 8'h03; step("R8 clear all"); quiet();
        // R4 up/down mode
        pwm_mode_i = 1; ovf_evt_i = 1; step("R4 wrap ignored"); quiet();
        chk("R4 no ovf", {31'b0, flags_o[0]}, 32'h0);
        dir_down_i = 1; step("R4 turn down no set");
        dir_down_i = 1; step("R4 counting down");
        dir_down_i = 0; step("R4 turn up sets");
        chk("R4 ovf set", {31'b0, flags_o[0]}, 32'h1);
        pwm_mode_i = 0;
        // R9 upper bits
        wr_en_i = 1; wr_data_i = 8'hFC; step("R9 upper write"); quiet();
        chk("R9 upper zero", {24'b0, flags_o & 8'hFC}, 32'h0);
        wr_en_i = 1; wr_data_i = 8'hFF; step("R9 full write"); quiet();

        // random mix
        seed_dummy = $urandom(32'h5EED_1234);
        for (int i = 0; i < 3000; i++) begin
            cmp_evt_i  = ($urandom % 6) == 0;
            ovf_evt_i  = ($urandom % 6) == 0;
            wr_en_i    = ($urandom % 5) == 0;
            wr_data_i  = 8'($urandom);
            ack_i      = (($urandom % 5) == 0) ? 2'($urandom) : 2'b00;
            gie_i      = ($urandom % 4) != 0;
            ien_i      = 2'($urandom);
            if (($urandom % 100) == 0) pwm_mode_i = ~pwm_mode_i;
            if (($urandom % 4) == 0) dir_down_i = ~dir_down_i;
            step("R2 R3 R4 R5 R6 R7 random");
        end
        quiet();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule